// File: doc/BRIEF.md
# Interrupt Posting and Clear Register

This block holds the pending state of eight interrupt sources in a small microcontroller interrupt controller. Each source has a request input, and a request sets that source's posted bit. The bit then stays set until software removes it. The posted vector is driven out of the block, together with a single combined pending line that the rest of the controller uses to decide whether to take an interrupt.

Software reaches the register through a simple CPU register port. A read at the register's address returns the posted vector. A write has one of two effects, chosen by a global software-injection enable input:

- With the enable low, each data bit written as 0 removes its posted interrupt, and each bit written as 1 keeps its current state.
- With the enable high, each data bit written as 1 posts an interrupt for that source, and each bit written as 0 keeps its current state.

Because clearing takes a 0, firmware can clear one source without disturbing the others. It does this by writing all ones except the bit it wants cleared.

Top module: `irq_post_reg`

## Requirements
- R1: After a synchronous reset, all eight posted bits are 0, the pending output is 0 and read data is 0.
- R2: While the read strobe is high and the bus address equals REG_ADDR, read data equals the posted vector in the same cycle. With any other address, or with the read strobe low, read data is 0.
- R3: With the injection enable low (clear mode), a write at REG_ADDR with data bit i equal to 0 makes posted bit i equal to 0 after the clock edge. If that bit was already 0, it stays 0.
- R4: In clear mode, a write at REG_ADDR with data bit i equal to 1 leaves posted bit i unchanged.
- R5: With the injection enable high (inject mode), a write at REG_ADDR with data bit i equal to 0 leaves posted bit i unchanged.
- R6: In inject mode, a write at REG_ADDR with data bit i equal to 1 sets posted bit i to 1 after the clock edge.
- R7: A hardware request high on input bit i during a clock edge sets posted bit i at that edge. The bit stays set after the request goes low.
- R8: If a hardware request and a clear-mode write of 0 reach the same bit at the same edge, the bit ends up 1.
- R9: Writes to any address other than REG_ADDR change no posted bit, in either mode.
- R10: The pending output is 1 exactly when at least one posted bit is 1, in the same cycle as the posted vector.
- R11: Bit positions map to sources as follows:
  - bit 7: endpoint 3
  - bit 6: endpoint 2
  - bit 5: endpoint 1
  - bit 4: endpoint 0
  - bit 3: start-of-frame
  - bit 2: bus reset
  - bit 1: timer 2
  - bit 0: timer 1

  The request for each source sets only its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 8 | Per-source hardware request, bit i sets posted bit i |
| sw_inj_en | input | 1 | Global software-injection enable: 0 selects clear mode, 1 selects inject mode |
| bus_addr | input | 8 | CPU register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, the posted vector when selected, otherwise 0 |
| posted | output | 8 | Posted interrupt vector |
| irq_pending | output | 1 | High while any posted bit is 1 |

## Verification
The hardest situation to reach from the ports is a collision, where a hardware request and a software clear hit the same bit at the same clock edge. The bench brings this about by first loading a known vector through inject-mode writes. It then raises one source's request on the same falling edge on which it issues a clear-mode write of 0, so both act at the next rising edge. This is repeated for every source. The write semantics are covered by sweeping all 256 starting vectors against sixteen data patterns in both modes. Each starting vector is built through the port itself: a clear-all write followed by an inject write.

// File: rtl/irq_post_pkg.sv
package irq_post_pkg;

    localparam int SRC_N  = 8;
    localparam int ADDR_W = 8;

    // Bit index of each interrupt source inside the posted vector.
    typedef enum int unsigned {
        SRC_TIMER1  = 0,
        SRC_TIMER2  = 1,
        SRC_BUS_RST = 2,
        SRC_SOF     = 3,
        SRC_EP0     = 4,
        SRC_EP1     = 5,
        SRC_EP2     = 6,
        SRC_EP3     = 7
    } src_idx_e;

    typedef enum logic {
        MODE_CLEAR  = 1'b0,
        MODE_INJECT = 1'b1
    } wr_mode_e;

    typedef struct packed {
        logic     wr_hit;
        logic     rd_hit;
        wr_mode_e mode;
    } bus_cmd_t;

    // Next state of one posted bit. A hardware request always wins.
    function automatic logic post_next(
        input logic     cur,
        input logic     hw,
        input logic     wr,
        input wr_mode_e mode,
        input logic     d
    );
        logic sw;
        if (!wr) begin
            sw = cur;
        end else if (mode == MODE_INJECT) begin
            sw = cur | d;
        end else begin
            sw = cur & d;
        end
        return sw | hw;
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_post_pkg::*;
#(
    parameter int              AW       = ADDR_W,
    parameter logic [AW-1:0]   REG_ADDR = '0
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic          inj_en,
    output bus_cmd_t      cmd
);
    logic sel;

    always_comb begin
        sel        = (addr == REG_ADDR);
        cmd.wr_hit = sel & wr;
        cmd.rd_hit = sel & rd;
        cmd.mode   = inj_en ? MODE_INJECT : MODE_CLEAR;
    end
endmodule

// File: rtl/irq_post_cell.sv
module irq_post_cell
    import irq_post_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hw_set,
    input  logic     wr_en,
    input  wr_mode_e mode,
    input  logic     wbit,
    output logic     q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= post_next(q, hw_set, wr_en, mode, wbit);
        end
    end
endmodule

// File: rtl/irq_read_merge.sv
module irq_read_merge #(
    parameter int N = 8
) (
    input  logic [N-1:0] vec,
    input  logic         rd_hit,
    output logic [N-1:0] rdata,
    output logic         any
);
    always_comb begin
        rdata = rd_hit ? vec : '0;
        any   = |vec;
    end
endmodule

// File: rtl/irq_post_reg.sv
module irq_post_reg
    import irq_post_pkg::*;
#(
    parameter int                N        = SRC_N,
    parameter int                AW       = ADDR_W,
    parameter logic [AW-1:0]     REG_ADDR = 8'hDB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  hw_req,
    input  logic          sw_inj_en,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [N-1:0]  bus_wdata,
    input  logic          bus_rd,
    output logic [N-1:0]  bus_rdata,
    output logic [N-1:0]  posted,
    output logic          irq_pending
);
    bus_cmd_t cmd;

    irq_bus_decode #(.AW(AW), .REG_ADDR(REG_ADDR)) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .inj_en (sw_inj_en),
        .cmd    (cmd)
    );

    for (genvar i = 0; i < N; i++) begin : g_bit
        irq_post_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .hw_set (hw_req[i]),
            .wr_en  (cmd.wr_hit),
            .mode   (cmd.mode),
            .wbit   (bus_wdata[i]),
            .q      (posted[i])
        );
    end

    irq_read_merge #(.N(N)) u_merge (
        .vec    (posted),
        .rd_hit (cmd.rd_hit),
        .rdata  (bus_rdata),
        .any    (irq_pending)
    );
endmodule

// File: rtl/irq_post_chk.sv
module irq_post_chk #(
    parameter int            N        = 8,
    parameter int            AW       = 8,
    parameter logic [AW-1:0] REG_ADDR = '0
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  hw_req,
    input logic          sw_inj_en,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [N-1:0]  bus_wdata,
    input logic          bus_rd,
    input logic [N-1:0]  bus_rdata,
    input logic [N-1:0]  posted,
    input logic          irq_pending
);
    logic          rst_q;
    logic          hit_wr;
    logic [N-1:0]  may_set;
    logic [N-1:0]  may_clr;

    always_ff @(posedge clk) rst_q <= rst;

    always_comb begin
        hit_wr  = bus_wr && (bus_addr == REG_ADDR);
        may_set = hw_req | ((hit_wr && sw_inj_en) ? bus_wdata : '0);
        may_clr = (hit_wr && !sw_inj_en) ? ~bus_wdata : '0;
    end

    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            AST_RESET_CLEAR: assert (posted == '0); // R1
        end
    end

    always_comb begin
        if (!rst && bus_rd && bus_addr == REG_ADDR) begin
            AST_READ_VALUE: assert (bus_rdata == posted); // R2
        end
        if (!rst) begin
            AST_PEND_ANY: assert (irq_pending == ($countones(posted) != 0)); // R10
        end
    end

    AST_HW_SETS: assert property (@(posedge clk) disable iff (rst)
        (hw_req != '0) |=> ((posted & $past(hw_req)) == $past(hw_req))); // R7

    AST_NO_SPUR_SET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((posted & ~$past(posted) & ~$past(may_set)) == '0)); // R4

    AST_NO_SPUR_CLR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~posted & $past(posted) & ~$past(may_clr)) == '0)); // R5

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (may_clr != '0) |=> ((posted & $past(may_clr) & ~$past(hw_req)) == '0)); // R3
endmodule

bind irq_post_reg irq_post_chk #(.N(N), .AW(AW), .REG_ADDR(REG_ADDR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hw_req      (hw_req),
    .sw_inj_en   (sw_inj_en),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .posted      (posted),
    .irq_pending (irq_pending)
);

// File: tb/test_irq_post_reg.sv
module test_irq_post_reg;
    localparam int       CLK_PERIOD = 10;
    localparam logic [7:0] RA = 8'hDB;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] hw_req;
    logic       sw_inj_en;
    logic [7:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic       bus_rd;
    logic [7:0] bus_rdata;
    logic [7:0] posted;
    logic       irq_pending;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_post_reg #(.REG_ADDR(RA)) i_irq_post_reg (
        .clk(clk), .rst(rst), .hw_req(hw_req), .sw_inj_en(sw_inj_en),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .posted(posted),
        .irq_pending(irq_pending)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic mode);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; sw_inj_en = mode; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic load_state(input logic [7:0] s);
        bus_write(RA, 8'h00, 1'b0);
        bus_write(RA, s, 1'b1);
    endtask

    task automatic read_check(input string tag, input logic [7:0] exp);
        bus_addr = RA; bus_rd = 1'b1;
        #1;
        check(tag, bus_rdata, exp);
        check("R10 pending", {7'd0, irq_pending}, {7'd0, exp != 8'h00});
        bus_addr = RA ^ 8'h01;
        #1;
        check("R2 other address reads 0", bus_rdata, 8'h00);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; hw_req = '0; sw_inj_en = 1'b0; bus_addr = '0;
        bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 posted", posted, 8'h00);
        check("R1 pending", {7'd0, irq_pending}, 8'h00);
        bus_addr = RA; bus_rd = 1'b1; #1;
        check("R1 rdata", bus_rdata, 8'h00);
        bus_rd = 1'b0;

        // R3 R4 R5 R6: sweep start vectors, data patterns, both modes
        for (int s = 0; s < 256; s++) begin
            for (int k = 0; k < 16; k++) begin
                for (int m = 0; m < 2; m++) begin
                    logic [7:0] d;
                    logic [7:0] e;
                    d = 8'(k * 17) ^ 8'(s * 3);
                    e = (m == 1) ? (8'(s) | d) : (8'(s) & d);
                    load_state(8'(s));
                    bus_write(RA, d, m[0]);
                    if (m == 1) check("R5/R6 inject write", posted, e);
                    else        check("R3/R4 clear write", posted, e);
                    if (k == 0) read_check("R2 read", e);
                end
            end
        end

        // R9: other addresses ignored
        for (int a = 0; a < 256; a++) begin
            if (8'(a) != RA) begin
                load_state(8'hA5);
                bus_write(8'(a), 8'h00, 1'b0);
                bus_write(8'(a), 8'hFF, 1'b1);
                check("R9 foreign address", posted, 8'hA5);
            end
        end

        // R7 R11: each source sets only its own bit
        for (int i = 0; i < 8; i++) begin
            load_state(8'h00);
            @(negedge clk);
            hw_req = 8'(1 << i);
            @(negedge clk);
            hw_req = '0;
            @(negedge clk);
            check("R7/R11 source bit", posted, 8'(1 << i));
            read_check("R2 read after request", 8'(1 << i));
        end

        // R8: hardware set beats same-cycle clear
        for (int i = 0; i < 8; i++) begin
            load_state(8'hFF);
            @(negedge clk);
            hw_req = 8'(1 << i);
            bus_addr = RA; bus_wdata = 8'h00; sw_inj_en = 1'b0; bus_wr = 1'b1;
            @(negedge clk);
            hw_req = '0; bus_wr = 1'b0;
            check("R8 set wins", posted, 8'(1 << i));
        end

        // R3 clear of an absent bit, then R10 on empty vector
        load_state(8'h00);
        bus_write(RA, 8'h00, 1'b0);
        check("R3 clear of empty", posted, 8'h00);
        check("R10 idle", {7'd0, irq_pending}, 8'h00);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule